// File: doc/BRIEF.md
# I2C Byte Engine with Deferred Acknowledge

This block moves one byte at a time between a register-style host interface and the I2C data line. A separate bit-timing unit supplies two single-cycle strobes per bit: one at the SCL-low point, where SDA may change, and one at the SCL-high point, where SDA is sampled. The engine shifts one bit for each strobe pair, MSB first, and then handles the ninth (acknowledge) bit.

The host starts transfers as a side effect of data-register access. In transmit mode, writing the data register sends the byte. In receive mode, reading the data register returns the held byte and starts reception of the next one. Every completed byte, every lost arbitration and every address-match event raises an interrupt flag, which the host clears by writing one.

With fast acknowledge enabled in receive mode, the flag rises right after the eighth data bit. The engine then waits until the host writes the acknowledge bit, and only after that drives ACK or NACK in the ninth slot. START/STOP generation, address comparison and timeouts are outside the block; arbitration loss and address match each arrive as a single event input.

Top module: `i2c_byte_engine`

## Requirements
- R1: After reset, the data register reads 0x00, irq_flag=0, rx_ack=0, busy=0 and sda_out=1 (released).
- R2: While idle with mode_tx=1, a data write loads the data register and sets busy on the next cycle. Each scl_low_stb then puts the next bit on sda_out, MSB first. sda_out changes only on an scl_low_stb or on arbitration loss.
- R3: While idle with mode_tx=0, a data read returns the held byte and starts reception. sda_in is sampled on each scl_high_stb, MSB first. The assembled byte appears in the data register when the flag rises.
- R4: A data read while mode_tx=1 starts nothing. busy stays 0 and sda_out stays 1.
- R5: With fast acknowledge off, or in transmit mode, irq_flag rises and busy falls on the scl_high_stb of the ninth bit, and not before it. Every fall of busy comes with irq_flag=1.
- R6: With fast_ack_en=1 in receive mode, irq_flag rises and busy falls on the eighth scl_high_stb. SDA stays released until tx_ack_wr latches tx_ack_bit. The next scl_low_stb drives the latched value (0=ACK, 1=NACK), and the slot ends without a second flag.
- R7: In transmit mode, SDA is released during the ninth bit. rx_ack captures sda_in at that bit's scl_high_stb: 0 means acknowledged, 1 means no acknowledge.
- R8: In receive mode with fast acknowledge off, the ninth-bit scl_low_stb drives the current tx_ack_bit level onto sda_out.
- R9: flag_clr=1 clears irq_flag. A set event in the same cycle wins, and the flag never falls without flag_clr.
- R10: arb_lost aborts the byte. On the next cycle busy=0, sda_out=1 and irq_flag=1.
- R11: addr_match sets irq_flag on the next cycle.
- R12: A data write while busy is ignored. The data register and the bits on the bus are unchanged.
- R13: Once a byte has ended, the next scl_low_stb while idle releases SDA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_data_en | input | 1 | Host write strobe for the data register |
| wr_data | input | DATA_W | Host write data |
| rd_data_en | input | 1 | Host read strobe for the data register |
| rd_data | output | DATA_W | Data register contents |
| mode_tx | input | 1 | 1 = transmit, 0 = receive |
| fast_ack_en | input | 1 | Flag before the acknowledge slot in receive mode |
| tx_ack_bit | input | 1 | Acknowledge value to send (0=ACK, 1=NACK) |
| tx_ack_wr | input | 1 | Host write strobe of tx_ack_bit, releases a fast-ACK hold |
| flag_clr | input | 1 | Write-one-to-clear strobe for irq_flag |
| irq_flag | output | 1 | Interrupt pending |
| rx_ack | output | 1 | Acknowledge sampled after a transmitted byte |
| busy | output | 1 | Byte transfer in progress |
| scl_low_stb | input | 1 | SCL-low point strobe (SDA update) |
| scl_high_stb | input | 1 | SCL-high point strobe (SDA sample) |
| sda_in | input | 1 | SDA line level |
| sda_out | output | 1 | SDA drive, 1 = released |
| arb_lost | input | 1 | Arbitration-lost event |
| addr_match | input | 1 | Address-match event |

## Verification
Every result is one register stage from its cause. busy follows a starting access on the next cycle. sda_out follows the scl_low_stb that moves it on the next cycle. irq_flag, rx_ack and the received byte follow the completing scl_high_stb on the next cycle. The bench drives every strobe and host access for one cycle between rising edges. It samples at the falling edge right after the rising edge that consumes the stimulus, so each check lands exactly one register stage later. The sweeps send and receive all 256 byte values, with and without fast acknowledge, and derive each acknowledge value from bits of the byte.

// File: rtl/i2cb_pkg.sv
package i2cb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DATA,
    ST_ACK,
    ST_HOLD,
    ST_ACKF
  } eng_state_t;
endpackage

// File: rtl/i2cb_shifter.sv
module i2cb_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift_en,
  input  logic         fill,
  output logic         msb,
  output logic [W-1:0] sh_next
);
  logic [W-1:0] sh_q;

  always_comb begin
    if (load)
      sh_next = load_val;
    else if (shift_en)
      sh_next = {sh_q[W-2:0], fill};
    else
      sh_next = sh_q;
  end

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= sh_next;
  end

  assign msb = sh_q[W-1];
endmodule

// File: rtl/i2cb_datareg.sv
module i2cb_datareg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_tx,
  input  logic [W-1:0] tx_val,
  input  logic         store_rx,
  input  logic [W-1:0] rx_val,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)           q <= '0;
    else if (load_tx)  q <= tx_val;
    else if (store_rx) q <= rx_val;
  end
endmodule

// File: rtl/i2cb_flags.sv
module i2cb_flags (
  input  logic clk,
  input  logic rst,
  input  logic set_evt,
  input  logic clr,
  input  logic ack_cap,
  input  logic ack_val,
  output logic irq,
  output logic rxack
);
  always_ff @(posedge clk) begin
    if (rst) begin
      irq   <= 1'b0;
      rxack <= 1'b0;
    end else begin
      if (set_evt)  irq <= 1'b1;
      else if (clr) irq <= 1'b0;
      if (ack_cap)  rxack <= ack_val;
    end
  end
endmodule

// File: rtl/i2cb_seq.sv
module i2cb_seq
  import i2cb_pkg::*;
#(
  parameter int W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic wr_data_en,
  input  logic rd_data_en,
  input  logic mode_tx,
  input  logic fast_ack_en,
  input  logic tx_ack_bit,
  input  logic tx_ack_wr,
  input  logic scl_low_stb,
  input  logic scl_high_stb,
  input  logic sda_in,
  input  logic arb_lost,
  input  logic sh_msb,
  output logic sda_out,
  output logic busy,
  output logic load_sh,
  output logic shift_en,
  output logic shift_fill,
  output logic store_rx,
  output logic ack_cap,
  output logic done_evt
);
  localparam int CNT_W = (W > 2) ? $clog2(W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

  eng_state_t st;
  logic [CNT_W-1:0] cnt;
  logic dir_tx, ack_hold;
  logic start_tx, start_rx, last_bit, fast_stop, ack_end;

  always_comb begin
    start_tx   = (st == ST_IDLE) && wr_data_en && mode_tx;
    start_rx   = (st == ST_IDLE) && rd_data_en && !mode_tx;
    last_bit   = (st == ST_DATA) && scl_high_stb && (cnt == LAST);
    fast_stop  = last_bit && !dir_tx && fast_ack_en;
    ack_end    = (st == ST_ACK) && scl_high_stb;
    load_sh    = start_tx && !arb_lost;
    shift_en   = !arb_lost && (st == ST_DATA) &&
                 (dir_tx ? scl_low_stb : scl_high_stb);
    shift_fill = dir_tx ? 1'b0 : sda_in;
    ack_cap    = !arb_lost && ack_end && dir_tx;
    store_rx   = !arb_lost && !dir_tx && (ack_end || fast_stop);
    done_evt   = !arb_lost && (ack_end || fast_stop);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      dir_tx   <= 1'b0;
      ack_hold <= 1'b1;
      sda_out  <= 1'b1;
      busy     <= 1'b0;
    end else if (arb_lost) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      sda_out <= 1'b1;
      busy    <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (scl_low_stb) sda_out <= 1'b1;
          if (start_tx) begin
            st     <= ST_DATA;
            dir_tx <= 1'b1;
            busy   <= 1'b1;
            cnt    <= '0;
          end else if (start_rx) begin
            st     <= ST_DATA;
            dir_tx <= 1'b0;
            busy   <= 1'b1;
            cnt    <= '0;
          end
        end
        ST_DATA: begin
          if (scl_low_stb) sda_out <= dir_tx ? sh_msb : 1'b1;
          if (scl_high_stb) begin
            if (cnt == LAST) begin
              cnt <= '0;
              if (!dir_tx && fast_ack_en) begin
                st   <= ST_HOLD;
                busy <= 1'b0;
              end else begin
                st <= ST_ACK;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        ST_ACK: begin
          if (scl_low_stb) sda_out <= dir_tx ? 1'b1 : tx_ack_bit;
          if (scl_high_stb) begin
            st   <= ST_IDLE;
            busy <= 1'b0;
          end
        end
        ST_HOLD: begin
          if (tx_ack_wr) begin
            ack_hold <= tx_ack_bit;
            st       <= ST_ACKF;
          end
        end
        ST_ACKF: begin
          if (scl_low_stb)  sda_out <= ack_hold;
          if (scl_high_stb) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_data_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_data_en,
  output logic [DATA_W-1:0] rd_data,
  input  logic              mode_tx,
  input  logic              fast_ack_en,
  input  logic              tx_ack_bit,
  input  logic              tx_ack_wr,
  input  logic              flag_clr,
  output logic              irq_flag,
  output logic              rx_ack,
  output logic              busy,
  input  logic              scl_low_stb,
  input  logic              scl_high_stb,
  input  logic              sda_in,
  output logic              sda_out,
  input  logic              arb_lost,
  input  logic              addr_match
);
  logic              sh_msb, load_sh, shift_en, shift_fill;
  logic              store_rx, ack_cap, done_evt;
  logic [DATA_W-1:0] sh_next;

  i2cb_seq #(.W(DATA_W)) u_seq (
    .clk(clk), .rst(rst),
    .wr_data_en(wr_data_en), .rd_data_en(rd_data_en),
    .mode_tx(mode_tx), .fast_ack_en(fast_ack_en),
    .tx_ack_bit(tx_ack_bit), .tx_ack_wr(tx_ack_wr),
    .scl_low_stb(scl_low_stb), .scl_high_stb(scl_high_stb),
    .sda_in(sda_in), .arb_lost(arb_lost), .sh_msb(sh_msb),
    .sda_out(sda_out), .busy(busy), .load_sh(load_sh),
    .shift_en(shift_en), .shift_fill(shift_fill),
    .store_rx(store_rx), .ack_cap(ack_cap), .done_evt(done_evt)
  );

  i2cb_shifter #(.W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .load(load_sh), .load_val(wr_data),
    .shift_en(shift_en), .fill(shift_fill),
    .msb(sh_msb), .sh_next(sh_next)
  );

  i2cb_datareg #(.W(DATA_W)) u_dreg (
    .clk(clk), .rst(rst), .load_tx(load_sh), .tx_val(wr_data),
    .store_rx(store_rx), .rx_val(sh_next), .q(rd_data)
  );

  i2cb_flags u_flags (
    .clk(clk), .rst(rst),
    .set_evt(done_evt | arb_lost | addr_match),
    .clr(flag_clr), .ack_cap(ack_cap), .ack_val(sda_in),
    .irq(irq_flag), .rxack(rx_ack)
  );
endmodule

// File: rtl/i2cb_checker.sv
module i2cb_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         wr_data_en,
  input logic         rd_data_en,
  input logic         mode_tx,
  input logic         scl_low_stb,
  input logic         scl_high_stb,
  input logic         arb_lost,
  input logic         addr_match,
  input logic         flag_clr,
  input logic         sda_out,
  input logic         busy,
  input logic         irq_flag,
  input logic [W-1:0] rd_data
);
  assert_sda_moves_on_low_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(sda_out)) |-> ($past(scl_low_stb) || $past(arb_lost)));

  assert_tx_read_idle_R4: assert property (@(posedge clk) disable iff (rst)
    (!busy && rd_data_en && mode_tx && !wr_data_en && !arb_lost) |=> !busy);

  assert_busy_end_flags_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $fell(busy)) |-> irq_flag);

  assert_flag_w1c_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $fell(irq_flag)) |-> $past(flag_clr));

  assert_arb_abort_R10: assert property (@(posedge clk) disable iff (rst)
    arb_lost |=> (!busy && sda_out && irq_flag));

  assert_addr_flag_R11: assert property (@(posedge clk) disable iff (rst)
    addr_match |=> irq_flag);

  assert_busy_write_ignored_R12: assert property (@(posedge clk) disable iff (rst)
    (busy && wr_data_en && !scl_high_stb) |=> $stable(rd_data));
endmodule

bind i2c_byte_engine i2cb_checker #(.W(DATA_W)) u_checker (
  .clk(clk), .rst(rst), .wr_data_en(wr_data_en), .rd_data_en(rd_data_en),
  .mode_tx(mode_tx), .scl_low_stb(scl_low_stb), .scl_high_stb(scl_high_stb),
  .arb_lost(arb_lost), .addr_match(addr_match), .flag_clr(flag_clr),
  .sda_out(sda_out), .busy(busy), .irq_flag(irq_flag), .rd_data(rd_data)
);

// File: tb/test_i2c_byte_engine.sv
module test_i2c_byte_engine;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_data_en = 0, rd_data_en = 0, mode_tx = 1, fast_ack_en = 0;
  logic       tx_ack_bit = 0, tx_ack_wr = 0, flag_clr = 0;
  logic       scl_low_stb = 0, scl_high_stb = 0, sda_in = 1;
  logic       arb_lost = 0, addr_match = 0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       irq_flag, rx_ack, busy, sda_out;
  int         checks = 0, errors = 0;

  always #10 clk = ~clk;

  i2c_byte_engine #(.DATA_W(8)) i_i2c_byte_engine (
    .clk(clk), .rst(rst), .wr_data_en(wr_data_en), .wr_data(wr_data),
    .rd_data_en(rd_data_en), .rd_data(rd_data), .mode_tx(mode_tx),
    .fast_ack_en(fast_ack_en), .tx_ack_bit(tx_ack_bit), .tx_ack_wr(tx_ack_wr),
    .flag_clr(flag_clr), .irq_flag(irq_flag), .rx_ack(rx_ack), .busy(busy),
    .scl_low_stb(scl_low_stb), .scl_high_stb(scl_high_stb), .sda_in(sda_in),
    .sda_out(sda_out), .arb_lost(arb_lost), .addr_match(addr_match)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic bit_step(input logic sin, output logic seen);
    @(negedge clk); scl_low_stb = 1;
    @(negedge clk); scl_low_stb = 0; seen = sda_out; sda_in = sin; scl_high_stb = 1;
    @(negedge clk); scl_high_stb = 0; sda_in = 1;
  endtask

  task automatic low_pulse();
    @(negedge clk); scl_low_stb = 1;
    @(negedge clk); scl_low_stb = 0;
  endtask

  task automatic clear_flag();
    @(negedge clk); flag_clr = 1;
    @(negedge clk); flag_clr = 0;
  endtask

  task automatic tx_byte(input logic [7:0] v, input logic ack, input logic fast);
    logic [7:0] got;
    logic s;
    mode_tx = 1; fast_ack_en = fast;
    @(negedge clk); wr_data_en = 1; wr_data = v;
    @(negedge clk); wr_data_en = 0;
    chk("R2 busy after write", busy, 1);
    for (int i = 0; i < 8; i++) begin
      bit_step(1'b1, s);
      got[7-i] = s;
    end
    chk("R2 serial byte MSB first", got, v);
    chk("R5 no flag before ninth bit", irq_flag, 0);
    bit_step(ack, s);
    chk("R7 SDA released in ack slot", s, 1);
    chk("R5 flag after ninth bit", irq_flag, 1);
    chk("R5 busy cleared", busy, 0);
    chk("R7 rx_ack", rx_ack, ack);
    chk("R2 data register", rd_data, v);
    clear_flag();
    chk("R9 flag cleared", irq_flag, 0);
  endtask

  task automatic rx_byte(input logic [7:0] v, input logic ack, input logic fast);
    logic [7:0] prev;
    logic s, all_rel;
    mode_tx = 0; fast_ack_en = fast; tx_ack_bit = ack;
    prev = rd_data;
    @(negedge clk); rd_data_en = 1;
    chk("R3 read returns held byte", rd_data, prev);
    @(negedge clk); rd_data_en = 0;
    chk("R3 busy after read", busy, 1);
    all_rel = 1;
    for (int i = 0; i < 8; i++) begin
      bit_step(v[7-i], s);
      all_rel &= s;
    end
    chk("R3 SDA released while receiving", all_rel, 1);
    if (!fast) begin
      chk("R5 no flag before ninth bit", irq_flag, 0);
      bit_step(1'b1, s);
      chk("R8 ack level driven", s, ack);
      chk("R5 flag after ninth bit", irq_flag, 1);
      chk("R5 busy cleared", busy, 0);
      chk("R3 received byte", rd_data, v);
      clear_flag();
    end else begin
      chk("R6 early flag", irq_flag, 1);
      chk("R6 busy cleared early", busy, 0);
      chk("R3 received byte", rd_data, v);
      clear_flag();
      low_pulse();
      chk("R6 SDA held released", sda_out, 1);
      @(negedge clk); tx_ack_wr = 1; tx_ack_bit = ack;
      @(negedge clk); tx_ack_wr = 0; tx_ack_bit = ~ack;
      bit_step(1'b1, s);
      chk("R6 latched ack driven", s, ack);
      chk("R6 no second flag", irq_flag, 0);
    end
    low_pulse();
    chk("R13 SDA released when idle", sda_out, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic s;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 data reset", rd_data, 8'h00);
    chk("R1 flag reset", irq_flag, 0);
    chk("R1 rx_ack reset", rx_ack, 0);
    chk("R1 busy reset", busy, 0);
    chk("R1 SDA released", sda_out, 1);

    // R4: read while transmitting starts nothing
    mode_tx = 1;
    @(negedge clk); rd_data_en = 1;
    @(negedge clk); rd_data_en = 0;
    chk("R4 no busy", busy, 0);
    low_pulse();
    chk("R4 SDA released", sda_out, 1);

    // R11 and R9
    @(negedge clk); addr_match = 1;
    @(negedge clk); addr_match = 0;
    chk("R11 flag from address match", irq_flag, 1);
    @(negedge clk); flag_clr = 1; addr_match = 1;
    @(negedge clk); flag_clr = 0; addr_match = 0;
    chk("R9 set wins over clear", irq_flag, 1);
    clear_flag();
    chk("R9 clear", irq_flag, 0);

    for (int v = 0; v < 256; v++) tx_byte(8'(v), v[0] ^ v[3], 1'b0);
    for (int v = 0; v < 256; v++) rx_byte(8'(v), v[1], 1'b0);
    for (int v = 0; v < 256; v++) rx_byte(8'(v), v[2] ^ v[5], 1'b1);
    tx_byte(8'h5A, 1'b0, 1'b1);  // R6: fast ack ignored in transmit
    tx_byte(8'hC3, 1'b1, 1'b1);

    // R12: write during a byte is ignored
    begin
      logic [7:0] got;
      mode_tx = 1; fast_ack_en = 0;
      @(negedge clk); wr_data_en = 1; wr_data = 8'hA5;
      @(negedge clk); wr_data_en = 0;
      for (int i = 0; i < 8; i++) begin
        if (i == 2) begin
          @(negedge clk); wr_data_en = 1; wr_data = 8'h3C;
          @(negedge clk); wr_data_en = 0;
        end
        bit_step(1'b1, s);
        got[7-i] = s;
      end
      chk("R12 bus byte unchanged", got, 8'hA5);
      chk("R12 data register unchanged", rd_data, 8'hA5);
      bit_step(1'b0, s);
      clear_flag();
    end

    // R10: arbitration lost mid-byte
    mode_tx = 1;
    @(negedge clk); wr_data_en = 1; wr_data = 8'h00;
    @(negedge clk); wr_data_en = 0;
    for (int i = 0; i < 3; i++) bit_step(1'b1, s);
    low_pulse();
    chk("R2 SDA driven low", sda_out, 0);
    @(negedge clk); arb_lost = 1;
    @(negedge clk); arb_lost = 0;
    chk("R10 busy cleared", busy, 0);
    chk("R10 SDA released", sda_out, 1);
    chk("R10 flag set", irq_flag, 1);
    clear_flag();
    tx_byte(8'h81, 1'b0, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule